// File: doc/BRIEF.md
# Configuration Start-Up Sequencer

This block carries a programmable device from the moment its configuration load finishes to normal operation. A one-cycle load-complete strobe starts the sequence. The block then steps through four start-up phases and raises three release events, each in a phase chosen by a 2-bit selector. The three events are: letting the DONE line go high, enabling the user I/Os, and removing the global set/reset. The phases advance on clock-enable ticks taken from either the configuration clock or a user clock, so the block itself runs on one clock. An optional gate holds the sequence until an externally observed DONE-in level has passed through a synchronizer.

A low level on the program input aborts whatever is in progress and returns the block to configuration. On that return it emits a restart pulse, which tells the surrounding logic to sample the mode pins again. It also emits a memory-clear pulse. Three option bits are captured from the bit stream at each load-complete strobe and take effect on the following reprogram:
- one keeps configuration memory, for partial reconfiguration;
- one keeps the I/Os enabled through reconfiguration;
- one keeps the global set/reset released through reconfiguration.

Top module: `cfg_startup_seq`

## Requirements
- R1: After reset, `configuring`=1, `active`=0, `done_release`=0, `io_enable`=0, `gsr_n`=0, `restart`=0 and `mem_clear`=0. The internal reset is released two clock edges after `rst_n` rises.
- R2: While configuring, a `load_done` strobe moves the block to a waiting step. With the sync gate off, the first selected tick enters phase 1. Each further tick advances one phase. A tick in phase 4 enters the active state. Clock edges without a tick change nothing.
- R3: `opt_use_uclk`=1 takes ticks from `uclk_en` and ignores `cclk_en`. `opt_use_uclk`=0 does the reverse.
- R4: Selector value s (0..3) in `sel_done`, `sel_io` or `sel_gsr` places its event in phase s+1. The event output goes high on the clock edge after that phase is entered. `gsr_n` high means the global set/reset is released.
- R5: Once high, `done_release`, `io_enable` and `gsr_n` stay high until a program event. Later selector changes have no effect on them.
- R6: With `opt_sync_done`=1, the waiting step passes to phase 1 only on a selected tick at which `done_in`, as sampled two selected ticks earlier, was high. `done_in` is sampled only on selected ticks.
- R7: In the active state, ticks and `load_done` are ignored. All three event outputs are high.
- R8: When `prog_n` is first sampled low at edge E, the block is configuring after edge E+2. On that same edge `restart` pulses for one cycle and `done_release` drops. This holds from any state.
- R9: `mem_clear` pulses together with `restart`, unless the keep-memory option was set at the last `load_done` in the configuring state.
- R10: A program event drops `io_enable`, unless `bs_hold_io` was latched at the last load. It drops `gsr_n`, unless `bs_hold_gsr` was latched.
- R11: A `prog_n` low period of any length gives exactly one program event. A program event takes priority over a `load_done` strobe seen on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_n | input | 1 | Asynchronous program request, active low |
| load_done | input | 1 | One-cycle strobe: configuration load complete |
| cclk_en | input | 1 | Configuration-clock tick enable |
| uclk_en | input | 1 | User-clock tick enable |
| opt_use_uclk | input | 1 | 1: phases advance on user-clock ticks |
| opt_sync_done | input | 1 | 1: wait for synchronized DONE-in before phase 1 |
| done_in | input | 1 | External DONE line level |
| sel_done | input | 2 | Phase select (0..3 = phase 1..4) for DONE release |
| sel_io | input | 2 | Phase select for I/O enable |
| sel_gsr | input | 2 | Phase select for set/reset release |
| bs_keep_mem | input | 1 | Bit-stream option: skip memory clear on next reprogram |
| bs_hold_io | input | 1 | Bit-stream option: keep I/Os enabled on next reprogram |
| bs_hold_gsr | input | 1 | Bit-stream option: keep set/reset released on next reprogram |
| configuring | output | 1 | Block is in configuration |
| active | output | 1 | Start-up complete |
| done_release | output | 1 | 1: stop pulling DONE low |
| io_enable | output | 1 | 1: user I/Os driven |
| gsr_n | output | 1 | Global set/reset, active low |
| restart | output | 1 | One-cycle pulse: resample mode pins |
| mem_clear | output | 1 | One-cycle pulse: clear configuration memory |

## Verification
The assertions check the following on every cycle:
- a program event always lands in configuration with a restart pulse;
- DONE stays low while configuring;
- the three event outputs never fall without a program event;
- the active state holds all events high and is left only through a program event;
- a memory clear never appears without a restart;
- the waiting step advances, or is held by the DONE-in gate, as its inputs demand.

Only the bench scenarios can show that each selector value puts its event in the right phase. The same holds for tick selection between the two clock sources, the two-tick delay of the DONE-in synchronizer, one event per long program pulse, and the options latched at load taking effect on the next reprogram.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
  localparam int N_PHASE = 4;
  localparam int N_EVT   = 3;
  localparam int SEL_W   = $clog2(N_PHASE);

  typedef enum logic [2:0] {
    ST_CFG  = 3'd0,
    ST_WAIT = 3'd1,
    ST_P1   = 3'd2,
    ST_P2   = 3'd3,
    ST_P3   = 3'd4,
    ST_P4   = 3'd5,
    ST_ACT  = 3'd6
  } seq_state_t;
endpackage

// File: rtl/cfgseq_sync.sv
module cfgseq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  chain <= RST_VAL;
        else if (en) chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  chain <= {STAGES{RST_VAL}};
        else if (en) chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgseq_phase_fsm.sv
module cfgseq_phase_fsm
  import cfgseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 prog_evt,
  input  logic                 load_done,
  input  logic                 tick,
  input  logic                 sync_mode,
  input  logic                 done_seen,
  output seq_state_t           state,
  output logic [N_PHASE-1:0]   phase_oh
);
  seq_state_t nxt;

  always_comb begin
    nxt = state;
    if (prog_evt) begin
      nxt = ST_CFG;
    end else begin
      case (state)
        ST_CFG:  if (load_done) nxt = ST_WAIT;
        ST_WAIT: if (tick && (!sync_mode || done_seen)) nxt = ST_P1;
        ST_P1:   if (tick) nxt = ST_P2;
        ST_P2:   if (tick) nxt = ST_P3;
        ST_P3:   if (tick) nxt = ST_P4;
        ST_P4:   if (tick) nxt = ST_ACT;
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_CFG;
    else        state <= nxt;
  end

  generate
    for (genvar i = 0; i < N_PHASE; i++) begin : g_oh
      assign phase_oh[i] = (int'(state) == int'(ST_P1) + i);
    end
  endgenerate
endmodule

// File: rtl/cfgseq_release.sv
module cfgseq_release
  import cfgseq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_PHASE-1:0]     phase_oh,
  input  logic [N_EVT*SEL_W-1:0] sel,
  input  logic                   prog_evt,
  input  logic [N_EVT-1:0]       keep_on_prog,
  output logic [N_EVT-1:0]       flags
);
  generate
    for (genvar g = 0; g < N_EVT; g++) begin : g_evt
      logic [SEL_W-1:0] s;
      logic             hit;
      assign s   = sel[g*SEL_W +: SEL_W];
      assign hit = phase_oh[s];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flags[g] <= 1'b0;
        end else if (prog_evt) begin
          if (!keep_on_prog[g]) flags[g] <= 1'b0;
        end else if (hit) begin
          flags[g] <= 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
  import cfgseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_n,
  input  logic             load_done,
  input  logic             cclk_en,
  input  logic             uclk_en,
  input  logic             opt_use_uclk,
  input  logic             opt_sync_done,
  input  logic             done_in,
  input  logic [SEL_W-1:0] sel_done,
  input  logic [SEL_W-1:0] sel_io,
  input  logic [SEL_W-1:0] sel_gsr,
  input  logic             bs_keep_mem,
  input  logic             bs_hold_io,
  input  logic             bs_hold_gsr,
  output logic             configuring,
  output logic             active,
  output logic             done_release,
  output logic             io_enable,
  output logic             gsr_n,
  output logic             restart,
  output logic             mem_clear
);
  localparam int EV_DONE = 0;
  localparam int EV_IO   = 1;
  localparam int EV_GSR  = 2;

  logic [1:0]         rst_pipe;
  logic               srst_n;
  logic               prog_s, prog_prev, prog_evt;
  logic               tick, done_seen;
  logic               keep_mem_q, hold_io_q, hold_gsr_q;
  logic               load_take;
  seq_state_t         state;
  logic [N_PHASE-1:0] phase_oh;
  logic [N_EVT-1:0]   flags, keep_vec;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  cfgseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_prog_sync (
    .clk(clk), .rst_n(srst_n), .en(1'b1), .d(prog_n), .q(prog_s)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) prog_prev <= 1'b1;
    else         prog_prev <= prog_s;
  end
  assign prog_evt = prog_prev & ~prog_s;

  assign tick = opt_use_uclk ? uclk_en : cclk_en;

  cfgseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_done_sync (
    .clk(clk), .rst_n(srst_n), .en(tick), .d(done_in), .q(done_seen)
  );

  cfgseq_phase_fsm u_fsm (
    .clk(clk), .rst_n(srst_n), .prog_evt(prog_evt), .load_done(load_done),
    .tick(tick), .sync_mode(opt_sync_done), .done_seen(done_seen),
    .state(state), .phase_oh(phase_oh)
  );

  // bit-stream options captured at load complete, used on next reprogram
  assign load_take = !prog_evt && (state == ST_CFG) && load_done;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      keep_mem_q <= 1'b0;
      hold_io_q  <= 1'b0;
      hold_gsr_q <= 1'b0;
    end else if (load_take) begin
      keep_mem_q <= bs_keep_mem;
      hold_io_q  <= bs_hold_io;
      hold_gsr_q <= bs_hold_gsr;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      restart   <= 1'b0;
      mem_clear <= 1'b0;
    end else begin
      restart   <= prog_evt;
      mem_clear <= prog_evt & ~keep_mem_q;
    end
  end

  assign keep_vec[EV_DONE] = 1'b0;
  assign keep_vec[EV_IO]   = hold_io_q;
  assign keep_vec[EV_GSR]  = hold_gsr_q;

  cfgseq_release u_rel (
    .clk(clk), .rst_n(srst_n), .phase_oh(phase_oh),
    .sel({sel_gsr, sel_io, sel_done}), .prog_evt(prog_evt),
    .keep_on_prog(keep_vec), .flags(flags)
  );

  assign done_release = flags[EV_DONE];
  assign io_enable    = flags[EV_IO];
  assign gsr_n        = flags[EV_GSR];
  assign configuring  = (state == ST_CFG);
  assign active       = (state == ST_ACT);
endmodule

// File: rtl/cfgseq_checker.sv
module cfgseq_checker
  import cfgseq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       prog_evt,
  input logic       tick,
  input logic       sync_mode,
  input logic       done_seen,
  input seq_state_t state,
  input logic       configuring,
  input logic       active,
  input logic       done_release,
  input logic       io_enable,
  input logic       gsr_n,
  input logic       restart,
  input logic       mem_clear
);
  AST_PROG_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    prog_evt |=> (configuring && restart)); // R8

  AST_DONE_LOW_CONFIG: assert property (@(posedge clk) disable iff (!rst_n)
    configuring |-> !done_release); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_evt && done_release) |=> done_release); // R5

  AST_IO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_evt && io_enable) |=> io_enable); // R5

  AST_GSR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_evt && gsr_n) |=> gsr_n); // R5

  AST_ACTIVE_ALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (done_release && io_enable && gsr_n)); // R7

  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !prog_evt) |=> active); // R7

  AST_MEMCLR_WITH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clear |-> restart); // R9

  AST_WAIT_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && tick && !sync_mode && !prog_evt) |=> state == ST_P1); // R2

  AST_SYNC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && sync_mode && !done_seen && !prog_evt) |=> state == ST_WAIT); // R6
endmodule

bind cfg_startup_seq cfgseq_checker u_chk (
  .clk(clk), .rst_n(srst_n), .prog_evt(prog_evt), .tick(tick),
  .sync_mode(opt_sync_done), .done_seen(done_seen), .state(state),
  .configuring(configuring), .active(active), .done_release(done_release),
  .io_enable(io_enable), .gsr_n(gsr_n), .restart(restart), .mem_clear(mem_clear)
);

// File: tb/cfg_startup_seq_test.sv
module cfg_startup_seq_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, prog_n, load_done, cclk_en, uclk_en, opt_use_uclk, opt_sync_done, done_in;
  logic [1:0] sel_done, sel_io, sel_gsr;
  logic bs_keep_mem, bs_hold_io, bs_hold_gsr;
  logic configuring, active, done_release, io_enable, gsr_n, restart, mem_clear;

  cfg_startup_seq uut (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .load_done(load_done),
    .cclk_en(cclk_en), .uclk_en(uclk_en), .opt_use_uclk(opt_use_uclk),
    .opt_sync_done(opt_sync_done), .done_in(done_in), .sel_done(sel_done),
    .sel_io(sel_io), .sel_gsr(sel_gsr), .bs_keep_mem(bs_keep_mem),
    .bs_hold_io(bs_hold_io), .bs_hold_gsr(bs_hold_gsr),
    .configuring(configuring), .active(active), .done_release(done_release),
    .io_enable(io_enable), .gsr_n(gsr_n), .restart(restart), .mem_clear(mem_clear)
  );

  int vectors = 0;
  int fails   = 0;
  string cur_req = "R1";

  // tick generators
  int cper = 1, uper = 1, ccnt = 0, ucnt = 0;
  always @(negedge clk) begin
    ccnt = ccnt + 1;
    ucnt = ucnt + 1;
    cclk_en = (ccnt % cper) == 0;
    uclk_en = (ucnt % uper) == 0;
  end

  // behavioural reference: phase number 0=config 1=wait 2..5=phase1..4 6=active
  int mph = 0, rcnt = 0;
  bit started = 0;
  bit ex_done, ex_io, ex_gsr, ex_restart, ex_memclr;
  bit k_mem, k_io, k_gsr;
  bit m_evt, m_tk;
  bit pq[$];
  bit dq[$];

  always @(posedge clk) begin
    started = 1;
    if (!rst_n || rcnt < 2) begin
      if (rst_n) rcnt = rcnt + 1; else rcnt = 0;
      mph = 0;
      ex_done = 0; ex_io = 0; ex_gsr = 0; ex_restart = 0; ex_memclr = 0;
      k_mem = 0; k_io = 0; k_gsr = 0;
      pq = '{1, 1, 1};
      dq = '{0, 0};
    end else begin
      m_evt = pq[pq.size()-3] && !pq[pq.size()-2];
      m_tk  = opt_use_uclk ? uclk_en : cclk_en;
      if (m_evt) begin
        ex_done = 0;
        if (!k_io)  ex_io  = 0;
        if (!k_gsr) ex_gsr = 0;
      end else begin
        if (mph == int'(sel_done) + 2) ex_done = 1;
        if (mph == int'(sel_io)   + 2) ex_io   = 1;
        if (mph == int'(sel_gsr)  + 2) ex_gsr  = 1;
      end
      ex_restart = m_evt;
      ex_memclr  = m_evt && !k_mem;
      if (!m_evt && mph == 0 && load_done) begin
        k_mem = bs_keep_mem; k_io = bs_hold_io; k_gsr = bs_hold_gsr;
      end
      if (m_evt) mph = 0;
      else if (mph == 0) begin if (load_done) mph = 1; end
      else if (mph == 1) begin
        if (m_tk && (!opt_sync_done || dq[dq.size()-2])) mph = 2;
      end else if (mph >= 2 && mph <= 5) begin
        if (m_tk) mph = mph + 1;
      end
      if (m_tk) dq.push_back(done_in);
      pq.push_back(prog_n);
      while (pq.size() > 6) void'(pq.pop_front());
      while (dq.size() > 6) void'(dq.pop_front());
    end
  end

  task automatic chk(input string name, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b at %0t", cur_req, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("configuring",  configuring,  mph == 0);
      chk("active",       active,       mph == 6);
      chk("done_release", done_release, ex_done);
      chk("io_enable",    io_enable,    ex_io);
      chk("gsr_n",        gsr_n,        ex_gsr);
      chk("restart",      restart,      ex_restart);
      chk("mem_clear",    mem_clear,    ex_memclr);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_load();
    load_done = 1; cyc(1); load_done = 0;
  endtask

  task automatic prog_pulse(input int n);
    prog_n = 0; cyc(n); prog_n = 1;
  endtask

  initial begin
    rst_n = 0; prog_n = 1; load_done = 0; opt_use_uclk = 0; opt_sync_done = 0;
    done_in = 0; sel_done = 0; sel_io = 0; sel_gsr = 0;
    bs_keep_mem = 0; bs_hold_io = 0; bs_hold_gsr = 0;
    cur_req = "R1"; // R1 reset state
    cyc(3); rst_n = 1; cyc(4);

    cur_req = "R2/R4"; // R2 phase walk, R4 selector placement
    sel_done = 0; sel_io = 1; sel_gsr = 3;
    cyc(1); pulse_load(); cyc(10);

    cur_req = "R7/R5"; // R7 active ignores inputs, R5 sticky outputs
    sel_done = 3; sel_io = 3; sel_gsr = 0;
    pulse_load(); cyc(6);

    cur_req = "R8/R9/R10/R11"; // long program pulse, one event
    prog_pulse(6); cyc(6);

    cur_req = "R3"; // user-clock ticks, config ticks ignored
    opt_use_uclk = 1; uper = 3; cper = 1;
    sel_done = 3; sel_io = 2; sel_gsr = 1;
    pulse_load(); cyc(22);
    prog_pulse(1); cyc(5);
    opt_use_uclk = 0; cper = 2; uper = 1;
    sel_done = 2; sel_io = 0; sel_gsr = 1;
    pulse_load(); cyc(14);
    cper = 1;

    cur_req = "R6"; // DONE-in gate through synchronizer
    prog_pulse(2); cyc(4);
    opt_sync_done = 1; done_in = 0;
    pulse_load(); cyc(10);
    done_in = 1; cyc(1); done_in = 0; cyc(6);
    done_in = 1; cyc(15);
    opt_sync_done = 0; done_in = 0;

    cur_req = "R9/R10"; // options latched at load used on next program
    prog_pulse(2); cyc(4);
    bs_keep_mem = 1; bs_hold_io = 1; bs_hold_gsr = 1;
    sel_done = 1; sel_io = 0; sel_gsr = 2;
    pulse_load(); cyc(10);
    bs_keep_mem = 0; bs_hold_io = 0; bs_hold_gsr = 0;
    prog_pulse(3); cyc(6);
    bs_keep_mem = 1;
    pulse_load(); cyc(3);
    prog_pulse(2); cyc(6);

    cur_req = "R8/R11"; // abort mid-phase, program beats load
    pulse_load(); cyc(3);
    prog_pulse(2); cyc(5);
    load_done = 1; prog_n = 0; cyc(5); prog_n = 1; cyc(2); load_done = 0;
    cyc(10);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule